// File: doc/BRIEF.md
# Base Address Register Bank

This block keeps the six base address registers of one configuration function. Each slot is fixed at build time with a region size (a power of two, or zero when the slot is not implemented) and a space flag for I/O or memory. Configuration accesses carry a byte offset, an access length and write data. Full-word writes that land on an implemented slot are consumed here. Every other write is flagged for the generic configuration storage next door.

A full write with an ordinary value moves the region. The low address bits are cleared to the space's alignment, the region becomes valid, and a one-cycle remap pulse names the slot, so address decoders can drop the old window and open the new one. A write of zero or all-ones is the sizing probe software uses. It changes only the value read back and leaves the live mapping alone. The read-back value always carries the size mask and the space flag. Reads return the selected byte lanes one cycle after the request.

Top module: `bar_bank`

## Requirements
- R1: Slot n (n = 0..5) answers at byte offset 0x10 + 4*n; offsets below 0x10 or from 0x28 upward belong to no slot.
- R2: A write counts as full only with length code 2 (four bytes) and offset bits [1:0] equal to zero. A narrow write, a write to a slot of size zero, or a write outside the window changes no slot state and no read-back value, and raises `fwd_wr` for the one cycle after the request.
- R3: A full write of 0x00000000 or 0xFFFFFFFF to an implemented slot leaves that slot's base and valid flag unchanged and gives no remap pulse.
- R4: Any other full write to an implemented slot sets its base to the written value with bits [1:0] cleared (I/O) or bits [3:0] cleared (memory), and sets valid, both visible from the cycle after the request.
- R5: After any full write to an implemented slot, the read-back value is the written value ANDed with the inverse of (size - 1), ORed with the space flag in bit 0 (1 for I/O, 0 for memory). Each configured size is a power of two, at least 4 for I/O and at least 16 for memory.
- R6: After reset every base reads all-ones, every valid flag is 0, and every implemented slot reads back its space flag alone.
- R7: A remapping write (R4) gives `remap_pulse` high for exactly the one cycle after the request, with `remap_idx` set to the slot number.
- R8: A read answers in the cycle after the request. Length code 0 returns one byte, code 1 two bytes, codes 2 and 3 four bytes: the read-back value shifted right by 8*offset[1:0], with the unselected upper bytes zero, and `rd_claim` high. A read of an unimplemented slot or outside the window returns zero with `rd_claim` low and `fwd_rd` high.
- R9: A read and a write in the same cycle to the same slot return the read-back value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_wr | input | 1 | Configuration write request |
| acc_rd | input | 1 | Configuration read request |
| acc_off | input | 8 | Byte offset in configuration space |
| acc_len | input | 2 | Length code: 0 byte, 1 halfword, 2 word |
| acc_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, one cycle after the request |
| rd_claim | output | 1 | Read was served by this bank |
| fwd_rd | output | 1 | Read belongs to generic storage |
| fwd_wr | output | 1 | Write belongs to generic storage |
| region_base | output | 192 | Decoded base per slot, slot n in bits 32n+31:32n |
| region_valid | output | 6 | Mapping active per slot |
| remap_pulse | output | 1 | One-cycle pulse when a slot is moved |
| remap_idx | output | 3 | Slot that was moved |

## Verification
A read and a write can reach the same slot in one cycle. The read must then report the value held before the write, while the slot moves and pulses remap. The bench issues both at once, some as directed cases and some drawn at random. It compares the read data against the model's value taken before the write, and it checks the new base and the remap pulse in the same sampling cycle.

// File: rtl/bar_bank_pkg.sv
package bar_bank_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        LEN_BYTE = 2'd0,
        LEN_HALF = 2'd1,
        LEN_WORD = 2'd2,
        LEN_WIDE = 2'd3
    } acc_len_e;

    typedef struct packed {
        logic [WORD_W-1:0] readback;
        logic [WORD_W-1:0] base;
        logic              live;
        logic              moved;
    } slot_state_t;

    typedef struct packed {
        logic [WORD_W-1:0] rdata;
        logic              claim;
        logic              fwd_rd;
        logic              fwd_wr;
    } port_state_t;

endpackage

// File: rtl/bar_window_dec.sv
module bar_window_dec #(
    parameter int OFF_W     = 8,
    parameter int WIN_START = 16,
    parameter int NUM_SLOTS = 6,
    parameter int IDX_W     = 3
) (
    input  logic [OFF_W-1:0] off,
    input  logic [1:0]       len,
    output logic             in_window,
    output logic             word_access,
    output logic [IDX_W-1:0] slot_idx
);
    localparam int WIN_END = WIN_START + 4 * NUM_SLOTS;

    int unsigned off_i;
    int unsigned rel_i;

    always_comb begin
        off_i       = int'(off);
        in_window   = (off_i >= WIN_START) && (off_i < WIN_END);
        rel_i       = in_window ? ((off_i - WIN_START) >> 2) : 0;
        slot_idx    = rel_i[IDX_W-1:0];
        word_access = (len == 2'd2) && (off[1:0] == 2'b00);
    end
endmodule

// File: rtl/bar_lane_sel.sv
module bar_lane_sel (
    input  logic [31:0] word,
    input  logic [1:0]  byte_off,
    input  logic [1:0]  len,
    output logic [31:0] lanes
);
    logic [31:0] shifted;

    always_comb begin
        shifted = word >> {byte_off, 3'b000};
        case (len)
            2'd0:    lanes = {24'h0, shifted[7:0]};
            2'd1:    lanes = {16'h0, shifted[15:0]};
            default: lanes = shifted;
        endcase
    end
endmodule

// File: rtl/bar_slot.sv
module bar_slot
    import bar_bank_pkg::*;
#(
    parameter logic [31:0] SIZE  = 32'd16,
    parameter bit          IS_IO = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_sel,
    input  logic [31:0] wdata,
    output logic [31:0] readback,
    output logic [31:0] base,
    output logic        live,
    output logic        moved
);
    localparam logic [31:0] SIZE_MASK  = ~(SIZE - 32'd1);
    localparam logic [31:0] SPACE_FLAG = IS_IO ? 32'd1 : 32'd0;
    localparam logic [31:0] ALIGN_KEEP = IS_IO ? ~32'd3 : ~32'd15;
    localparam logic [31:0] MIN_SIZE   = IS_IO ? 32'd4 : 32'd16;

    slot_state_t st_d, st_q;
    logic        probe_val;

    always_comb begin
        st_d       = st_q;
        st_d.moved = 1'b0;
        probe_val  = (wdata == 32'h0) || (wdata == 32'hFFFF_FFFF);
        if (wr_sel) begin
            st_d.readback = (wdata & SIZE_MASK) | SPACE_FLAG;
            if (!probe_val) begin
                st_d.base  = wdata & ALIGN_KEEP;
                st_d.live  = 1'b1;
                st_d.moved = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.readback <= SPACE_FLAG;
            st_q.base     <= 32'hFFFF_FFFF;
            st_q.live     <= 1'b0;
            st_q.moved    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign readback = st_q.readback;
    assign base     = st_q.base;
    assign live     = st_q.live;
    assign moved    = st_q.moved;

    initial begin
        AST_SIZE_LEGAL: assert (((SIZE & (SIZE - 32'd1)) == 32'd0) && (SIZE >= MIN_SIZE)) else $error("illegal region size"); // R5
    end

    AST_PROBE_KEEPS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sel && ((wdata == 32'h0) || (wdata == 32'hFFFF_FFFF)) |=> $stable(base) && $stable(live) && !moved); // R3
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_sel |=> $stable(readback) && $stable(base)); // R2
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        live |-> ((base & ~ALIGN_KEEP) == 32'h0)); // R4
    AST_INVALID_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        !live |-> (base == 32'hFFFF_FFFF)); // R6
    AST_MOVE_IMPLIES_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        moved |-> live); // R7
endmodule

// File: rtl/bar_bank.sv
module bar_bank
    import bar_bank_pkg::*;
#(
    parameter int NUM_REGIONS = 6,
    parameter int OFF_W       = 8,
    parameter int WIN_START   = 16,
    parameter logic [NUM_REGIONS*32-1:0] REGION_SIZES = {
        32'd0, 32'd4, 32'd256, 32'd0, 32'd4096, 32'd16},
    parameter logic [NUM_REGIONS-1:0] REGION_IS_IO = 6'b010001,
    localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      acc_wr,
    input  logic                      acc_rd,
    input  logic [OFF_W-1:0]          acc_off,
    input  logic [1:0]                acc_len,
    input  logic [31:0]               acc_wdata,
    output logic [31:0]               rd_data,
    output logic                      rd_claim,
    output logic                      fwd_rd,
    output logic                      fwd_wr,
    output logic [NUM_REGIONS*32-1:0] region_base,
    output logic [NUM_REGIONS-1:0]    region_valid,
    output logic                      remap_pulse,
    output logic [IDX_W-1:0]          remap_idx
);
    logic             in_window;
    logic             word_access;
    logic [IDX_W-1:0] slot_idx;

    logic [NUM_REGIONS-1:0] implemented;
    logic [NUM_REGIONS-1:0] wr_sel;
    logic [NUM_REGIONS-1:0] moved;
    logic [31:0]            readback [NUM_REGIONS];

    logic [31:0] sel_word;
    logic [31:0] lane_word;
    logic        slot_impl;
    logic        wr_take;
    logic        rd_take;

    port_state_t pt_d, pt_q;

    bar_window_dec #(
        .OFF_W     (OFF_W),
        .WIN_START (WIN_START),
        .NUM_SLOTS (NUM_REGIONS),
        .IDX_W     (IDX_W)
    ) dec_i (
        .off         (acc_off),
        .len         (acc_len),
        .in_window   (in_window),
        .word_access (word_access),
        .slot_idx    (slot_idx)
    );

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_slot
        localparam logic [31:0] SZ = REGION_SIZES[g*32 +: 32];
        assign wr_sel[g] = wr_take && (slot_idx == g[IDX_W-1:0]);
        if (SZ != 32'd0) begin : g_used
            assign implemented[g] = 1'b1;
            bar_slot #(
                .SIZE  (SZ),
                .IS_IO (REGION_IS_IO[g])
            ) slot_i (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr_sel   (wr_sel[g]),
                .wdata    (acc_wdata),
                .readback (readback[g]),
                .base     (region_base[g*32 +: 32]),
                .live     (region_valid[g]),
                .moved    (moved[g])
            );
        end else begin : g_empty
            assign implemented[g]          = 1'b0;
            assign readback[g]             = 32'h0;
            assign region_base[g*32 +: 32] = 32'hFFFF_FFFF;
            assign region_valid[g]         = 1'b0;
            assign moved[g]                = 1'b0;
        end
    end

    always_comb begin
        sel_word  = 32'h0;
        slot_impl = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (slot_idx == i[IDX_W-1:0]) begin
                sel_word  = readback[i];
                slot_impl = implemented[i];
            end
        end
        wr_take = acc_wr && in_window && slot_impl && word_access;
        rd_take = acc_rd && in_window && slot_impl;
    end

    bar_lane_sel lane_i (
        .word     (sel_word),
        .byte_off (acc_off[1:0]),
        .len      (acc_len),
        .lanes    (lane_word)
    );

    always_comb begin
        pt_d        = pt_q;
        pt_d.rdata  = rd_take ? lane_word : 32'h0;
        pt_d.claim  = rd_take;
        pt_d.fwd_rd = acc_rd && !rd_take;
        pt_d.fwd_wr = acc_wr && !wr_take;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pt_q <= '0;
        end else begin
            pt_q <= pt_d;
        end
    end

    always_comb begin
        remap_idx = '0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (moved[i]) remap_idx = i[IDX_W-1:0];
        end
    end

    assign remap_pulse = |moved;
    assign rd_data     = pt_q.rdata;
    assign rd_claim    = pt_q.claim;
    assign fwd_rd      = pt_q.fwd_rd;
    assign fwd_wr      = pt_q.fwd_wr;

    AST_ONE_REMAP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(moved)); // R7
    AST_REMAP_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        remap_pulse && !$past(wr_take) |-> 1'b0); // R7
    AST_READ_ROUTED_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_claim && fwd_rd)); // R8
    AST_FWD_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr && !wr_take |=> !remap_pulse); // R2
    AST_UNCLAIMED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_claim |-> (rd_data == 32'h0)); // R8
endmodule

// File: tb/bar_bank_tb_top.sv
module bar_bank_tb_top;
    localparam int N = 6;
    localparam logic [N*32-1:0] SIZES = {32'd0, 32'd4, 32'd256, 32'd0, 32'd4096, 32'd16};
    localparam logic [N-1:0]    IO    = 6'b010001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_wr = 1'b0;
    logic        acc_rd = 1'b0;
    logic [7:0]  acc_off = 8'h0;
    logic [1:0]  acc_len = 2'd0;
    logic [31:0] acc_wdata = 32'h0;
    logic [31:0] rd_data;
    logic        rd_claim, fwd_rd, fwd_wr, remap_pulse;
    logic [N*32-1:0] region_base;
    logic [N-1:0]    region_valid;
    logic [2:0]      remap_idx;

    int checks = 0;
    int errors = 0;

    logic [31:0] m_store [N];
    logic [31:0] m_base  [N];
    logic        m_live  [N];

    always #10 clk = ~clk;

    bar_bank #(
        .NUM_REGIONS (N),
        .OFF_W       (8),
        .WIN_START   (16),
        .REGION_SIZES(SIZES),
        .REGION_IS_IO(IO)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .acc_wr(acc_wr), .acc_rd(acc_rd),
        .acc_off(acc_off), .acc_len(acc_len), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .rd_claim(rd_claim), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr),
        .region_base(region_base), .region_valid(region_valid),
        .remap_pulse(remap_pulse), .remap_idx(remap_idx)
    );

    function automatic logic [31:0] sz(input int i);
        return SIZES[i*32 +: 32];
    endfunction

    function automatic logic [31:0] lanes(input logic [31:0] w, input logic [1:0] bo,
                                          input logic [1:0] len);
        logic [31:0] s;
        s = w >> (8 * bo);
        if (len == 2'd0) return s & 32'hFF;
        if (len == 2'd1) return s & 32'hFFFF;
        return s;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin
            m_store[i] = (sz(i) != 0) ? {31'h0, IO[i]} : 32'h0;
            m_base[i]  = 32'hFFFF_FFFF;
            m_live[i]  = 1'b0;
        end
    endtask

    task automatic check_map(input string tag);
        for (int i = 0; i < N; i++) begin
            chk(tag, region_base[i*32 +: 32], m_base[i]);
            chk(tag, {31'h0, region_valid[i]}, {31'h0, m_live[i]});
        end
    endtask

    task automatic do_op(input bit wr, input bit rd, input logic [7:0] off,
                         input logic [1:0] len, input logic [31:0] data);
        int  idx;
        bit  inwin, impl, full, mv;
        logic [31:0] e_rd;
        bit  e_claim;
        inwin = (off >= 8'h10) && (off < 8'h28);
        idx   = inwin ? (int'(off) - 16) / 4 : 0;
        impl  = inwin && (sz(idx) != 0);
        e_claim = rd && impl;
        e_rd    = e_claim ? lanes(m_store[idx], off[1:0], len) : 32'h0;
        full  = wr && impl && (len == 2'd2) && (off[1:0] == 2'b00);
        mv    = full && (data != 32'h0) && (data != 32'hFFFF_FFFF);
        if (full) begin
            m_store[idx] = (data & ~(sz(idx) - 1)) | {31'h0, IO[idx]};
            if (mv) begin
                m_base[idx] = data & (IO[idx] ? ~32'd3 : ~32'd15);
                m_live[idx] = 1'b1;
            end
        end
        @(negedge clk);
        acc_wr = wr; acc_rd = rd; acc_off = off; acc_len = len; acc_wdata = data;
        @(negedge clk);
        acc_wr = 1'b0; acc_rd = 1'b0;
        chk((wr && rd) ? "R9 same-cycle read" : "R8 read data", rd_data, e_rd);
        chk("R8 rd_claim", {31'h0, rd_claim}, {31'h0, e_claim});
        chk("R8 fwd_rd", {31'h0, fwd_rd}, {31'h0, rd && !e_claim});
        chk("R2 fwd_wr", {31'h0, fwd_wr}, {31'h0, wr && !full});
        chk("R7 remap_pulse", {31'h0, remap_pulse}, {31'h0, mv});
        if (mv) chk("R7 remap_idx", {29'h0, remap_idx}, idx);
        check_map((full && !mv) ? "R3 map kept" : "R4 map");
    endtask

    initial begin
        #3_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd5));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_map("R6 reset map");
        chk("R6 no pulse", {31'h0, remap_pulse}, 32'h0);
        // R6 reset read-back through the read port
        do_op(0, 1, 8'h10, 2'd2, 0);
        do_op(0, 1, 8'h14, 2'd2, 0);
        // R1 each offset reaches its own slot
        for (int i = 0; i < N; i++) do_op(1, 0, 8'h10 + 8'(4 * i), 2'd2, 32'hA000_0040 + 32'(i * 32'h100));
        // R4 R5 memory and I/O alignment
        do_op(1, 0, 8'h14, 2'd2, 32'h1234_5678);
        do_op(0, 1, 8'h14, 2'd2, 0);
        do_op(1, 0, 8'h10, 2'd2, 32'h0000_C003);
        do_op(0, 1, 8'h10, 2'd2, 0);
        // R3 sizing probes
        do_op(1, 0, 8'h14, 2'd2, 32'hFFFF_FFFF);
        do_op(0, 1, 8'h14, 2'd2, 0);
        do_op(1, 0, 8'h20, 2'd2, 32'h0);
        do_op(0, 1, 8'h20, 2'd2, 0);
        // R2 narrow, misaligned, unused slot, outside window
        do_op(1, 0, 8'h14, 2'd1, 32'h5555_5550);
        do_op(1, 0, 8'h16, 2'd2, 32'h5555_5550);
        do_op(1, 0, 8'h18, 2'd2, 32'h5555_5550);
        do_op(1, 0, 8'h08, 2'd2, 32'h5555_5550);
        do_op(0, 1, 8'h14, 2'd2, 0);
        // R8 lanes and unclaimed reads
        do_op(0, 1, 8'h15, 2'd0, 0);
        do_op(0, 1, 8'h16, 2'd1, 0);
        do_op(0, 1, 8'h17, 2'd3, 0);
        do_op(0, 1, 8'h24, 2'd2, 0);
        do_op(0, 1, 8'h2C, 2'd2, 0);
        // R9 read and write in one cycle
        do_op(1, 1, 8'h1C, 2'd2, 32'h8765_4321);
        do_op(1, 1, 8'h1C, 2'd2, 32'hFFFF_FFFF);
        // random mix
        for (int k = 0; k < 600; k++) begin
            logic [31:0] d;
            int sel;
            bit w, r;
            sel = int'($urandom % 8);
            d = (sel == 0) ? 32'h0 : (sel == 1) ? 32'hFFFF_FFFF : $urandom;
            w = 1'($urandom % 2);
            r = 1'($urandom % 2);
            if (!w && !r) r = 1'b1;
            do_op(w, r, 8'h08 + 8'($urandom % 40), ($urandom % 3 == 0) ? 2'($urandom % 4) : 2'd2, d);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule